// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block holds the eight-bit status byte of a serial flash memory and decides, request by request, whether an erase, a page program or a status-byte update may go ahead. The command decoder in front of it sends single-cycle pulses: write-enable set, write-enable clear, status update with its data byte, and erase or program with a kind code and a target address. The level of the external write-protect pin comes in directly. For every erase, program or status-update request the block answers with exactly one pulse, either grant or deny, in the cycle after the request.

A granted operation starts a built-in cycle counter that stands in for the self-timed array write. The busy flag stays set while the counter runs. Each operation kind has its own cycle count. When the counter expires, the write-enable latch clears itself. If the operation was a status update, the new protection bits are stored at that same moment. A two-bit protection level fences off the top quarter, the top half or the whole array. A status-lock bit freezes the protection bits, but only while the protect pin is held low. A bit-serial read port shifts out the live status byte, most significant bit first, and wraps around so the host can poll it repeatedly.

Top module: `flash_status_unit`

## Requirements
- R1: The status byte is laid out as follows. Bit 0 is busy (1 = a write is in progress). Bit 1 is write-enable. Bit 2 is protect level bit 0. Bit 3 is protect level bit 1. Bits 6:4 always read 0. Bit 7 is the status-lock bit. After reset the byte is 00h.
- R2: A write-enable set pulse sets bit 1 and a clear pulse clears it. If both arrive in the same cycle, the clear wins. Both pulses are ignored while busy is 1.
- R3: An erase, program or status-update request is granted only if write-enable is 1 and busy is 0. A refused request changes no status bit.
- R4: The protect level selects the protected addresses: 0 protects nothing, 1 protects 18000h–1FFFFh, 2 protects 10000h–1FFFFh, and 3 protects 00000h–1FFFFh.
- R5: The operation kind code selects the target range. Kind 0 is a small-sector erase of the 4 KB block picked by address bits 16:12. Kind 1 is a sector erase of the 32 KB block picked by bits 16:15. Kind 3 is a page program of the 256-byte page picked by bits 16:8. A request is refused if any byte of its target range is protected.
- R6: Kind 2, chip erase, is granted only at protect level 0.
- R7: A status update writes data bit 7 to the lock bit and data bits 3:2 to the protect level, and ignores all other data bits. The new values appear in the cycle in which busy falls.
- R8: A status update is refused while the lock bit is 1 and the protect pin is low. With the pin high, the lock bit has no effect.
- R9: After a grant, busy reads 1 for exactly T cycles, starting in the grant cycle. T is the count for the kind: 6 for small-sector erase, 8 for sector erase, 12 for chip erase, 4 for page program and 3 for status update.
- R10: Write-enable returns to 0 in the cycle in which busy falls after a granted operation.
- R11: A read-start pulse makes the serial bit show status bit 7. Each read-next pulse moves one bit lower, and after bit 0 comes bit 7 again. The bit always reflects the current status value.
- R12: Each erase, program or status-update request produces exactly one of grant or deny, as a pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wen_set_i | input | 1 | Write-enable set pulse |
| wen_clr_i | input | 1 | Write-enable clear pulse |
| sr_wr_req_i | input | 1 | Status update request pulse |
| sr_wr_data_i | input | 8 | Status update data byte |
| wp_pin_i | input | 1 | Write-protect pin level (low = protect) |
| op_req_i | input | 1 | Erase/program request pulse |
| op_kind_i | input | 2 | 0 small-sector erase, 1 sector erase, 2 chip erase, 3 page program |
| op_addr_i | input | 17 | Target byte address |
| rd_start_i | input | 1 | Restart the serial status read at bit 7 |
| rd_next_i | input | 1 | Advance the serial status read one bit |
| status_o | output | 8 | Live status byte |
| grant_o | output | 1 | Request granted pulse |
| deny_o | output | 1 | Request refused pulse |
| sr_bit_o | output | 1 | Current serial status bit |

## Verification
The assertions check the following on every cycle:
- Every request gets exactly one answer, and never both.
- The reserved bits stay 0.
- A granted request is seen as busy.
- Requests made while busy, or while write-enable is 0, are refused.
- A chip erase is never granted above level 0.
- Write-enable drops only on a clear pulse or at the end of a busy period.
- The protection bits change only when a timed operation finishes.

Only the bench scenarios can show the following: that the protect boundaries fall on the right addresses for each operation kind, that the busy period has the exact length for each kind, that the lock bit holds against the protect pin, and the wrapping order of the serial bit.

// File: rtl/flashsr_pkg.sv
package flashsr_pkg;

    typedef enum logic [1:0] {
        OP_SSE = 2'd0,
        OP_SE  = 2'd1,
        OP_CE  = 2'd2,
        OP_PP  = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic       lock;
        logic [2:0] rsvd;
        logic [1:0] level;
        logic       wen;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] level;
        logic       lock;
    } sr_pending_t;

    // lowest protected address for a protect level in an array of 2**aw bytes
    function automatic logic [31:0] prot_floor(input int aw, input logic [1:0] lvl);
        logic [31:0] f;
        case (lvl)
            2'd1:    f = 32'd3 << (aw - 2);
            2'd2:    f = 32'd1 << (aw - 1);
            2'd3:    f = 32'd0;
            default: f = 32'd1 << aw;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/protect_check.sv
module protect_check
    import flashsr_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int SMALL_W = 12,
    parameter int SEC_W   = 15,
    parameter int PAGE_W  = 8
) (
    input  logic [1:0]        level_i,
    input  op_kind_e          kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              allowed_o
);
    localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((1 << SMALL_W) - 1);
    localparam logic [ADDR_W-1:0] SEC_MASK   = ADDR_W'((1 << SEC_W) - 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK  = ADDR_W'((1 << PAGE_W) - 1);

    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W:0]   top_addr;
    logic [ADDR_W:0]   floor_addr;

    always_comb begin
        case (kind_i)
            OP_SSE:  span_mask = SMALL_MASK;
            OP_SE:   span_mask = SEC_MASK;
            OP_PP:   span_mask = PAGE_MASK;
            default: span_mask = '1;
        endcase
        top_addr   = {1'b0, addr_i | span_mask};
        floor_addr = (ADDR_W+1)'(prot_floor(ADDR_W, level_i));
        if (level_i == 2'd0)
            allowed_o = 1'b1;
        else if (kind_i == OP_CE)
            allowed_o = 1'b0;
        else
            allowed_o = top_addr < floor_addr;
    end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val_i;
        end else if (busy_q) begin
            if (done_o) busy_q <= 1'b0;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    a_r9_load_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> !busy_q);
    a_r9_load_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> (load_val_i != '0));
    a_r9_busy_after_load: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> busy_q);
endmodule

// File: rtl/sr_serializer.sv
module sr_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              next_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              bit_o
);
    localparam int POS_W = $clog2(BYTE_W);
    localparam logic [POS_W-1:0] TOP_POS = POS_W'(BYTE_W - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || start_i)
            pos_q <= TOP_POS;
        else if (next_i)
            pos_q <= (pos_q == '0) ? TOP_POS : pos_q - POS_W'(1);
    end

    assign bit_o = byte_i[pos_q];

    a_r11_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (next_i && !start_i && pos_q == '0) |=> (pos_q == TOP_POS));
    a_r11_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (pos_q == TOP_POS));
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import flashsr_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int SMALL_W = 12,
    parameter int SEC_W   = 15,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 16,
    parameter int T_SSE   = 6,
    parameter int T_SE    = 8,
    parameter int T_CE    = 12,
    parameter int T_PP    = 4,
    parameter int T_SRW   = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_wr_req_i,
    input  logic [7:0]        sr_wr_data_i,
    input  logic              wp_pin_i,
    input  logic              op_req_i,
    input  logic [1:0]        op_kind_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic              rd_start_i,
    input  logic              rd_next_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              sr_bit_o
);
    logic        wen_q;
    logic [1:0]  level_q;
    logic        lock_q;
    sr_pending_t pend_q;
    logic        grant_q, deny_q;

    logic        busy, tmr_done;
    logic        range_ok;
    logic        any_req, op_ok, sr_ok, accept;
    logic        sr_take;
    logic [CNT_W-1:0] load_val;
    op_kind_e    kind;
    status_t     st;

    logic unused_data_bits;
    assign unused_data_bits = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

    assign kind = op_kind_e'(op_kind_i);

    protect_check #(
        .ADDR_W (ADDR_W),
        .SMALL_W(SMALL_W),
        .SEC_W  (SEC_W),
        .PAGE_W (PAGE_W)
    ) u_prot (
        .level_i  (level_q),
        .kind_i   (kind),
        .addr_i   (op_addr_i),
        .allowed_o(range_ok)
    );

    always_comb begin
        any_req = op_req_i || sr_wr_req_i;
        op_ok   = !busy && wen_q && range_ok;
        sr_ok   = !busy && wen_q && !(lock_q && !wp_pin_i);
        accept  = op_req_i ? op_ok : (sr_wr_req_i && sr_ok);
        sr_take = sr_wr_req_i && !op_req_i && sr_ok;
        if (op_req_i) begin
            case (kind)
                OP_SSE:  load_val = CNT_W'(T_SSE);
                OP_SE:   load_val = CNT_W'(T_SE);
                OP_CE:   load_val = CNT_W'(T_CE);
                default: load_val = CNT_W'(T_PP);
            endcase
        end else begin
            load_val = CNT_W'(T_SRW);
        end
    end

    busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (any_req && accept),
        .load_val_i(load_val),
        .busy_o    (busy),
        .done_o    (tmr_done)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wen_q   <= 1'b0;
            level_q <= 2'b00;
            lock_q  <= 1'b0;
            pend_q  <= '0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= any_req && accept;
            deny_q  <= any_req && !accept;
            if (tmr_done) begin
                wen_q <= 1'b0;
                if (pend_q.valid) begin
                    level_q <= pend_q.level;
                    lock_q  <= pend_q.lock;
                    pend_q  <= '0;
                end
            end else if (!busy) begin
                if (wen_clr_i)      wen_q <= 1'b0;
                else if (wen_set_i) wen_q <= 1'b1;
            end
            if (sr_take) begin
                pend_q.valid <= 1'b1;
                pend_q.level <= sr_wr_data_i[3:2];
                pend_q.lock  <= sr_wr_data_i[7];
            end
        end
    end

    always_comb begin
        st.lock  = lock_q;
        st.rsvd  = 3'b000;
        st.level = level_q;
        st.wen   = wen_q;
        st.busy  = busy;
    end

    assign status_o = st;
    assign grant_o  = grant_q;
    assign deny_o   = deny_q;

    sr_serializer #(.BYTE_W(8)) u_ser (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(rd_start_i),
        .next_i (rd_next_i),
        .byte_i (status_o),
        .bit_o  (sr_bit_o)
    );

    a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o[6:4] == 3'b000);
    a_r12_single_answer: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({grant_o, deny_o}));
    a_r12_every_req_answered: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_req_i || sr_wr_req_i) |=> (grant_o || deny_o));
    a_r9_grant_shows_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        grant_o |-> status_o[0]);
    a_r3_busy_refused: assert property (@(posedge clk_i) disable iff (rst_i)
        ((op_req_i || sr_wr_req_i) && status_o[0]) |=> deny_o);
    a_r3_no_wen_refused: assert property (@(posedge clk_i) disable iff (rst_i)
        ((op_req_i || sr_wr_req_i) && !status_o[1]) |=> deny_o);
    a_r6_chip_erase_level: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_req_i && op_kind_i == 2'd2 && status_o[3:2] != 2'b00) |=> !grant_o);
    a_r8_lock_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (sr_wr_req_i && !op_req_i && status_o[7] && !wp_pin_i) |=> deny_o);
    a_r10_wen_fall_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(status_o[1]) |-> $past(wen_clr_i || tmr_done));
    a_r7_level_changes_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable({status_o[7], status_o[3:2]}) |-> $past(tmr_done));
endmodule

// File: tb/flash_status_unit_tb.sv
module flash_status_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        d_ws = 0, d_wc = 0, d_srq = 0, d_opq = 0, d_rs = 0, d_rn = 0;
    logic [7:0]  d_sd = 0;
    logic [1:0]  d_ok = 0;
    logic [16:0] d_oa = 0;
    logic        d_wp = 1;

    logic [7:0] status;
    logic       grant, deny, sbit;

    flash_status_unit dut_i (
        .clk_i(clk), .rst_i(rst),
        .wen_set_i(d_ws), .wen_clr_i(d_wc),
        .sr_wr_req_i(d_srq), .sr_wr_data_i(d_sd), .wp_pin_i(d_wp),
        .op_req_i(d_opq), .op_kind_i(d_ok), .op_addr_i(d_oa),
        .rd_start_i(d_rs), .rd_next_i(d_rn),
        .status_o(status), .grant_o(grant), .deny_o(deny), .sr_bit_o(sbit)
    );

    typedef struct packed {
        logic [7:0] st;
        logic       g;
        logic       d;
        logic       b;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_chk = 0, n_fail = 0;
    bit    done_flag = 0;

    // reference model built from the requirements
    bit       m_busy = 0, m_wen = 0, m_lock = 0, m_pv = 0, m_plock = 0;
    int       m_cnt = 0;
    bit [1:0] m_lvl = 0, m_plvl = 0;
    int       m_pos = 7;

    function automatic bit range_allowed(bit [1:0] lvl, bit [1:0] k, int a);
        int fl, hi;
        case (lvl)
            2'd1: fl = 'h18000;
            2'd2: fl = 'h10000;
            2'd3: fl = 0;
            default: fl = 'h20000;
        endcase
        if (lvl == 0) return 1;
        if (k == 2) return 0;
        case (k)
            2'd0: hi = a | 'hFFF;
            2'd1: hi = a | 'h7FFF;
            default: hi = a | 'hFF;
        endcase
        return hi < fl;
    endfunction

    function automatic int dur(bit [1:0] k);
        case (k)
            2'd0: return 6;
            2'd1: return 8;
            2'd2: return 12;
            default: return 4;
        endcase
    endfunction

    task automatic step(input string tag);
        bit pb, ok, g, d;
        bit [7:0] s;
        exp_t e;
        @(posedge clk);
        pb = m_busy; g = 0; d = 0;
        if (m_busy) begin
            if (m_cnt == 1) begin
                m_busy = 0; m_wen = 0;
                if (m_pv) begin m_lvl = m_plvl; m_lock = m_plock; m_pv = 0; end
            end else m_cnt--;
        end else begin
            if (d_wc) m_wen = 0;
            else if (d_ws) m_wen = 1;
        end
        if (d_opq || d_srq) begin
            if (d_opq) ok = range_allowed(m_lvl, d_ok, int'(d_oa));
            else       ok = !(m_lock && !d_wp);
            ok = ok && !pb && m_wen_pre(pb);
            if (ok) begin
                g = 1; m_busy = 1; m_cnt = d_opq ? dur(d_ok) : 3;
                if (!d_opq) begin m_pv = 1; m_plvl = d_sd[3:2]; m_plock = d_sd[7]; end
            end else d = 1;
        end
        if (d_rs) m_pos = 7;
        else if (d_rn) m_pos = (m_pos == 0) ? 7 : m_pos - 1;
        s = {m_lock, 3'b000, m_lvl, m_wen, m_busy};
        e.st = s; e.g = g; e.d = d; e.b = s[m_pos];
        q_exp.push_back(e);
        q_tag.push_back(tag);
        m_prev_wen = m_wen;
    endtask

    // write-enable as seen before this edge (busy blocks set/clear, so only done can change it)
    bit m_prev_wen = 0;
    function automatic bit m_wen_pre(bit pb);
        return pb ? 1'b0 : m_prev_wen;
    endfunction

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if (status !== e.st || grant !== e.g || deny !== e.d || sbit !== e.b) begin
                n_fail++;
                $display("FAIL %s: got st=%02h g=%0b d=%0b bit=%0b exp st=%02h g=%0b d=%0b bit=%0b",
                         t, status, grant, deny, sbit, e.st, e.g, e.d, e.b);
            end
        end
    end

    task automatic clear_drv();
        d_ws = 0; d_wc = 0; d_srq = 0; d_opq = 0; d_rs = 0; d_rn = 0;
    endtask

    task automatic cyc(input string tag);
        step(tag);
        @(negedge clk);
        clear_drv();
    endtask

    task automatic drain(input string tag);
        while (m_busy) cyc(tag);
        cyc(tag);
    endtask

    task automatic do_op(input string tag, input bit [1:0] k, input int a);
        d_ws = 1; cyc("R2");
        d_opq = 1; d_ok = k; d_oa = 17'(a); cyc(tag);
        drain(tag);
    endtask

    task automatic do_sr(input string tag, input bit [7:0] v);
        d_ws = 1; cyc("R2");
        d_srq = 1; d_sd = v; cyc(tag);
        drain(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset value
        cyc("R1"); cyc("R1");
        // R2 set, clear, both
        d_ws = 1; cyc("R2");
        d_wc = 1; cyc("R2");
        d_ws = 1; d_wc = 1; cyc("R2");
        // R3 program with write-enable low
        d_opq = 1; d_ok = 2'd3; d_oa = 17'h00100; cyc("R3");
        // R9/R10 page program busy length, with set and request during busy
        d_ws = 1; cyc("R2");
        d_opq = 1; d_ok = 2'd3; d_oa = 17'h1FF00; cyc("R9");
        d_wc = 1; cyc("R2");
        d_opq = 1; d_ok = 2'd0; d_oa = 0; cyc("R3");
        drain("R10");
        // R7 status update: only bits 7 and 3:2 land, at end of busy
        do_sr("R7", 8'hFF);
        // R6 chip erase refused at level 3 ; R4 whole array protected
        do_op("R6", 2'd2, 0);
        do_op("R4", 2'd3, 'h00000);
        // R8 lock with pin low
        d_wp = 0;
        do_sr("R8", 8'h00);
        d_wc = 1; cyc("R2");
        d_wp = 1;
        do_sr("R8", 8'h04);         // level 1, unlocked
        // level 1: R5 ranges
        do_op("R5", 2'd3, 'h17F00);
        do_op("R5", 2'd0, 'h17000);
        do_op("R5", 2'd0, 'h18000);
        do_op("R5", 2'd1, 'h10000);
        do_op("R5", 2'd1, 'h18000);
        do_op("R6", 2'd2, 0);
        d_wc = 1; cyc("R2");
        do_sr("R4", 8'h08);         // level 2
        do_op("R4", 2'd1, 'h08000);
        do_op("R4", 2'd1, 'h10000);
        do_op("R4", 2'd3, 'h0FF00);
        do_op("R4", 2'd3, 'h10000);
        d_wc = 1; cyc("R2");
        d_wp = 0;
        do_sr("R8", 8'h00);         // lock clear, so pin low does not matter
        d_wp = 1;
        do_op("R6", 2'd2, 'h00000);
        // R11 serial read idle, then during a busy period
        d_rs = 1; cyc("R11");
        for (int i = 0; i < 9; i++) begin d_rn = 1; cyc("R11"); end
        d_ws = 1; cyc("R11");
        d_rs = 1; cyc("R11");
        for (int i = 0; i < 7; i++) begin d_rn = 1; cyc("R11"); end
        d_opq = 1; d_ok = 2'd1; d_oa = 0; cyc("R12");
        while (m_busy) begin d_rn = 1; cyc("R11"); end
        cyc("R12"); cyc("R12");
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule